// File: doc/BRIEF.md
# Configuration Scrubbing Supervisor

This block supervises a reconfigurable device whose configuration memory can be upset by radiation. On a command from the host-side logic, it loads one stored configuration image into the device. The load runs one frame at a time through a byte-wide configuration port. Once the load is finished, and if scrubbing is enabled, it reads the device configuration back frame by frame without stopping. It compares every read byte against the stored copy, and bits marked as don't-care are left out of the compare.

A frame that disagrees with its stored copy is repaired in place. The port is turned to write direction, the stored frame is written again and followed by zero pad bytes, and the port returns to read direction. The device keeps running during the repair. A one-cycle repair pulse lets the host side raise an interrupt. Scrubbing then resumes at the repaired frame, which is read again. The host side can read the current state, the frame index, a load-complete flag and a saturating repair count on status outputs. The host side can also abort the current activity.

Top module: `cfg_scrubber`

## Requirements
- R1: After reset, `st_state` is 0 (idle), `st_load_done` and `st_fix_count` are 0, and `fix_irq`, `cfg_wr_en` and `cfg_rd_en` are low. The state codes are 0 idle, 1 load, 2 scrub and 3 repair.
- R2: A `host_start` seen in idle selects image `host_image` and enters load, which clears `st_load_done`. Each word takes two clock cycles. A flash read of address image*NFRAMES*FRAME_WORDS + frame*FRAME_WORDS + word is followed by a device write of the low byte of the returned flash word. `cfg_write` is high and `cfg_frame` carries the frame index. Frames run from 0 to NFRAMES-1.
- R3: Every frame written, in load or repair, is followed by PAD_WORDS device writes of 0x00.
- R4: After the last frame of a load, `st_load_done` is 1. If `scrub_en` is low, the block returns to idle and issues no device reads.
- R5: If `scrub_en` is high at the end of a load, scrubbing (state 2) starts by itself. It reads frames in order, and after frame NFRAMES-1 it wraps to frame 0.
- R6: Flash word bits [15:8] are a mask and bits [7:0] are configuration data. A read-back bit differing from the stored bit while its mask bit is 1 causes no repair.
- R7: A frame with an unmasked difference is rewritten from flash once the whole frame has been read, which restores its contents. `st_fix_count` increases by one.
- R8: On the cycle after a repair ends, `fix_irq` is high for exactly one cycle, the state is scrub, and `cfg_frame` still holds the repaired frame. That frame is read again next.
- R9: `st_fix_count` saturates at 2^CNTW-1.
- R10: `host_abort` in a non-idle state returns the block to idle at the end of the word in progress. After that, no device reads or writes are issued.
- R11: `host_start` outside idle is ignored: no load is entered and flash addresses stay within the active image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 MHz in the target system) |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_start | input | 1 | Load command from host side |
| host_image | input | $clog2(NIMAGES) | Image selected for a load |
| host_abort | input | 1 | Return to idle at the next word boundary |
| scrub_en | input | 1 | Start scrubbing after a load |
| flash_rd | output | 1 | Flash read strobe; data returns on the next cycle |
| flash_addr | output | $clog2(NIMAGES*NFRAMES*FRAME_WORDS) | Flash word address |
| flash_rdata | input | 2*DW | Stored word: mask byte over configuration byte |
| cfg_write | output | 1 | Configuration port direction, 1 = write |
| cfg_wr_en | output | 1 | Device write strobe |
| cfg_rd_en | output | 1 | Device read strobe; data returns on the next cycle |
| cfg_dout | output | DW | Byte written to the device |
| cfg_din | input | DW | Byte read from the device |
| cfg_frame | output | $clog2(NFRAMES) | Frame index addressed on the device |
| fix_irq | output | 1 | One-cycle pulse after each repair |
| st_state | output | 2 | Current state code |
| st_frame | output | $clog2(NFRAMES) | Current frame index |
| st_load_done | output | 1 | Last load completed |
| st_fix_count | output | CNTW | Saturating count of repaired frames |

## Verification
The assertions assume that the flash and the device each return data exactly one cycle after a read strobe. They also assume that `host_start` and `host_abort` are plain synchronous levels, with no meaning given to them in the same cycle as reset release. The bench models both memories as registered one-cycle reads and drives all host inputs on falling edges. It corrupts device bytes only while the block is scrubbing. It picks masked and unmasked byte positions from the known mask pattern of the stored image.

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
  parameter int NFRAMES     = 4,
  parameter int FRAME_WORDS = 4,
  parameter int PAD_WORDS   = 2,
  parameter int NIMAGES     = 4,
  parameter int DW          = 8,
  parameter int CNTW        = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          host_start,
  input  logic [$clog2(NIMAGES)-1:0]                    host_image,
  input  logic                                          host_abort,
  input  logic                                          scrub_en,
  output logic                                          flash_rd,
  output logic [$clog2(NIMAGES*NFRAMES*FRAME_WORDS)-1:0] flash_addr,
  input  logic [2*DW-1:0]                               flash_rdata,
  output logic                                          cfg_write,
  output logic                                          cfg_wr_en,
  output logic                                          cfg_rd_en,
  output logic [DW-1:0]                                 cfg_dout,
  input  logic [DW-1:0]                                 cfg_din,
  output logic [$clog2(NFRAMES)-1:0]                    cfg_frame,
  output logic                                          fix_irq,
  output logic [1:0]                                    st_state,
  output logic [$clog2(NFRAMES)-1:0]                    st_frame,
  output logic                                          st_load_done,
  output logic [CNTW-1:0]                               st_fix_count
);
  localparam int FRW = $clog2(NFRAMES);
  localparam int IMW = $clog2(NIMAGES);
  localparam int AW  = $clog2(NIMAGES*NFRAMES*FRAME_WORDS);
  localparam int WCW = $clog2(FRAME_WORDS+PAD_WORDS+1);
  localparam logic [FRW-1:0] LASTF   = FRW'(NFRAMES-1);
  localparam logic [WCW-1:0] NDATA   = WCW'(FRAME_WORDS);
  localparam logic [WCW-1:0] LASTRD  = WCW'(FRAME_WORDS-1);
  localparam logic [WCW-1:0] LASTWR  = WCW'(FRAME_WORDS+PAD_WORDS-1);

  typedef enum logic [1:0] {IDLE = 2'd0, LOAD = 2'd1, SCRUB = 2'd2, FIX = 2'd3} st_t;

  st_t            st;
  logic           ph;
  logic [WCW-1:0] wc;
  logic [FRW-1:0] frame;
  logic [IMW-1:0] img;
  logic           err, ld_done, abort_p, irq;
  logic [CNTW-1:0] fixes;
  logic           miss, stop, in_data;

  assign in_data    = wc < NDATA;
  assign stop       = host_abort | abort_p;
  assign miss       = |((cfg_din ^ flash_rdata[DW-1:0]) & ~flash_rdata[2*DW-1:DW]);
  assign cfg_write  = (st == LOAD) || (st == FIX);
  assign cfg_wr_en  = cfg_write && ph;
  assign cfg_rd_en  = (st == SCRUB) && !ph;
  assign flash_rd   = (st != IDLE) && !ph && in_data;
  assign flash_addr = AW'((32'(img) * NFRAMES + 32'(frame)) * FRAME_WORDS + 32'(wc));
  assign cfg_dout   = in_data ? flash_rdata[DW-1:0] : '0;
  assign cfg_frame  = frame;
  assign fix_irq    = irq;
  assign st_state   = st;
  assign st_frame   = frame;
  assign st_load_done = ld_done;
  assign st_fix_count = fixes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= 1'b0; wc <= '0; frame <= '0; img <= '0;
      err <= 1'b0; ld_done <= 1'b0; abort_p <= 1'b0; irq <= 1'b0; fixes <= '0;
    end else begin
      irq <= 1'b0;
      if (host_abort && st != IDLE) abort_p <= 1'b1;
      if (st == IDLE) begin
        abort_p <= 1'b0;
        err <= 1'b0;
        if (host_start) begin
          img <= host_image; st <= LOAD; ph <= 1'b0;
          wc <= '0; frame <= '0; ld_done <= 1'b0;
        end
      end else if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        if (stop) begin
          st <= IDLE; abort_p <= 1'b0; wc <= '0; err <= 1'b0;
        end else if (st == SCRUB) begin
          if (wc == LASTRD) begin
            wc <= '0; err <= 1'b0;
            if (err || miss) st <= FIX;
            else frame <= (frame == LASTF) ? '0 : frame + 1'b1;
          end else begin
            wc <= wc + 1'b1; err <= err | miss;
          end
        end else if (wc == LASTWR) begin
          wc <= '0;
          if (st == FIX) begin
            st <= SCRUB; irq <= 1'b1;
            if (~&fixes) fixes <= fixes + 1'b1;
          end else if (frame == LASTF) begin
            frame <= '0; ld_done <= 1'b1;
            st <= scrub_en ? SCRUB : IDLE;
          end else begin
            frame <= frame + 1'b1;
          end
        end else begin
          wc <= wc + 1'b1;
        end
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && host_start) |=> (st == LOAD && !ld_done && frame == '0));

  // R4
  done_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_done) |-> $past(st) == LOAD);

  // R8
  resume_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_irq |-> (st == SCRUB && $past(st) == FIX && frame == $past(frame)));

  // R9
  fix_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&fixes) |=> (&fixes));

  // R7
  fix_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_irq) |-> $stable(fixes) || $past(st) == FIX);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && ph && (host_abort || abort_p)) |=> (st == IDLE && !cfg_wr_en && !cfg_rd_en));
endmodule

// File: tb/sim_cfg_scrubber.sv
`timescale 1ns/1ps
module sim_cfg_scrubber;
  localparam int NF = 4, FW = 4, PW = 2, NI = 4, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_start = 1'b0, host_abort = 1'b0, scrub_en = 1'b0;
  logic [1:0] host_image = '0;
  logic flash_rd, cfg_write, cfg_wr_en, cfg_rd_en, fix_irq, st_load_done;
  logic [5:0] flash_addr;
  logic [15:0] flash_rdata = '0;
  logic [7:0] cfg_dout, cfg_din = '0;
  logic [1:0] cfg_frame, st_state, st_frame;
  logic [CW-1:0] st_fix_count;

  always #2 clk = ~clk;

  cfg_scrubber #(.NFRAMES(NF), .FRAME_WORDS(FW), .PAD_WORDS(PW), .NIMAGES(NI), .DW(8), .CNTW(CW)) u0 (
    .clk, .rst_n, .host_start, .host_image, .host_abort, .scrub_en,
    .flash_rd, .flash_addr, .flash_rdata, .cfg_write, .cfg_wr_en, .cfg_rd_en,
    .cfg_dout, .cfg_din, .cfg_frame, .fix_irq, .st_state, .st_frame,
    .st_load_done, .st_fix_count);

  function automatic logic [15:0] rom(input int a);
    logic [7:0] d, m;
    d = 8'(a * 29 + 7);
    m = (a % 5 == 2) ? 8'h0F : 8'h00;
    return {m, d};
  endfunction

  logic [7:0] dmem [NF*FW];
  int wcnt = 0, rcnt = 0, pads = 0, padbad = 0, rd_strobes = 0, wr_strobes = 0;
  int irq_cnt = 0, load_seen = 0, bad_addr = 0, wrap_seen = 0, exp_img = 0;
  logic [1:0] pf = '0;
  logic model_clr = 1'b0, corrupt_req = 1'b0;
  int corrupt_idx = 0;
  logic [7:0] corrupt_xor = '0;

  always @(posedge clk) begin
    if (flash_rd) begin
      flash_rdata <= rom(int'(flash_addr));
      if (int'(flash_addr) / (NF*FW) != exp_img) bad_addr <= bad_addr + 1;
    end
    if (cfg_rd_en) begin
      cfg_din <= dmem[int'(cfg_frame)*FW + rcnt];
      rcnt <= (rcnt == FW-1) ? 0 : rcnt + 1;
      rd_strobes <= rd_strobes + 1;
    end
    if (cfg_wr_en) begin
      if (!cfg_write) padbad <= padbad + 1;
      if (wcnt < FW) dmem[int'(cfg_frame)*FW + wcnt] <= cfg_dout;
      else begin
        pads <= pads + 1;
        if (cfg_dout != 8'h00) padbad <= padbad + 1;
      end
      wcnt <= (wcnt == FW+PW-1) ? 0 : wcnt + 1;
      wr_strobes <= wr_strobes + 1;
    end
    if (fix_irq) irq_cnt <= irq_cnt + 1;
    if (st_state == 2'd1) load_seen <= load_seen + 1;
    if (st_state == 2'd2 && pf == 2'd3 && cfg_frame == 2'd0) wrap_seen <= 1;
    pf <= cfg_frame;
    if (corrupt_req) dmem[corrupt_idx] <= dmem[corrupt_idx] ^ corrupt_xor;
    if (model_clr) begin rcnt <= 0; wcnt <= 0; end
  end

  int nchk = 0, nfail = 0;
  bit wd_hit = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_state(input logic [1:0] s, input int maxc, output bit ok);
    ok = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (st_state == s) begin ok = 1; break; end
    end
  endtask

  task automatic start_load(input int img, input bit sen);
    @(negedge clk);
    host_image = 2'(img); scrub_en = sen; host_start = 1'b1; exp_img = img;
    @(negedge clk);
    host_start = 1'b0;
  endtask

  task automatic corrupt(input int idx, input logic [7:0] x);
    @(negedge clk);
    corrupt_idx = idx; corrupt_xor = x; corrupt_req = 1'b1;
    @(negedge clk);
    corrupt_req = 1'b0;
  endtask

  task automatic image_matches(input int img, input string req);
    int bad = 0;
    for (int i = 0; i < NF*FW; i++)
      if (dmem[i] !== rom(img*NF*FW + i)[7:0]) bad++;
    chk(bad == 0, req, "device bytes differing from image", bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(st_state == 2'd0, "R1", "state after reset", int'(st_state), 0);
    chk(!st_load_done && st_fix_count == '0, "R1", "done/count after reset",
        int'(st_load_done) + int'(st_fix_count), 0);
    chk(!fix_irq && !cfg_wr_en && !cfg_rd_en, "R1", "strobes after reset",
        int'(fix_irq) + int'(cfg_wr_en) + int'(cfg_rd_en), 0);
  endtask

  task automatic t_load_only;
    bit ok;
    int p0 = pads, rd0;
    start_load(0, 1'b0);
    chk(st_state == 2'd1, "R2", "state after start", int'(st_state), 1);
    wait_state(2'd0, 200, ok);
    chk(ok, "R4", "returned to idle after load", int'(ok), 1);
    chk(st_load_done, "R4", "load_done after load", int'(st_load_done), 1);
    image_matches(0, "R2");
    chk(pads - p0 == NF*PW, "R3", "pad writes during load", pads - p0, NF*PW);
    chk(padbad == 0, "R3", "nonzero pad or bad direction", padbad, 0);
    rd0 = rd_strobes;
    idle_cycles(30);
    chk(rd_strobes == rd0, "R4", "device reads with scrub off", rd_strobes - rd0, 0);
  endtask

  task automatic t_load_scrub;
    bit ok;
    start_load(1, 1'b1);
    chk(!st_load_done, "R2", "load_done cleared at start", int'(st_load_done), 0);
    wait_state(2'd2, 200, ok);
    chk(ok, "R5", "scrub entered automatically", int'(ok), 1);
    chk(st_load_done, "R4", "load_done before scrub", int'(st_load_done), 1);
    image_matches(1, "R2");
    idle_cycles(100);
    chk(wrap_seen == 1, "R5", "frame wrap 3->0 seen", wrap_seen, 1);
    chk(irq_cnt == 0 && st_fix_count == '0, "R5", "repairs on clean image", irq_cnt, 0);
  endtask

  task automatic t_masked;
    int i0 = irq_cnt;
    corrupt(6, 8'h01);
    idle_cycles(120);
    chk(irq_cnt == i0, "R6", "repairs after masked flip", irq_cnt - i0, 0);
    chk(st_fix_count == '0, "R6", "fix count after masked flip", int'(st_fix_count), 0);
  endtask

  task automatic t_busy_start;
    int l0 = load_seen, b0 = bad_addr;
    @(negedge clk);
    host_image = 2'd0; host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    idle_cycles(70);
    chk(load_seen == l0, "R11", "load cycles after busy start", load_seen - l0, 0);
    chk(bad_addr == b0, "R11", "flash reads outside image", bad_addr - b0, 0);
  endtask

  task automatic fix_one(input int idx, input int frm, input int exp_cnt);
    bit seen = 0;
    int i0 = irq_cnt;
    corrupt(idx, 8'h80);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (fix_irq) begin seen = 1; break; end
    end
    chk(seen, "R7", "repair pulse seen", int'(seen), 1);
    chk(st_state == 2'd2 && cfg_frame == 2'(frm), "R8", "frame at repair pulse",
        int'(cfg_frame), frm);
    @(negedge clk);
    chk(!fix_irq, "R8", "pulse width", int'(fix_irq), 0);
    chk(int'(st_fix_count) == exp_cnt, "R9", "fix count", int'(st_fix_count), exp_cnt);
    chk(dmem[idx] == rom(NF*FW + idx)[7:0], "R7", "repaired byte", int'(dmem[idx]),
        int'(rom(NF*FW + idx)[7:0]));
    idle_cycles(80);
    chk(irq_cnt - i0 == 1, "R8", "repairs per upset", irq_cnt - i0, 1);
  endtask

  task automatic t_fix_and_saturate;
    int p0 = pads;
    fix_one(9, 2, 1);
    chk(pads - p0 == PW && padbad == 0, "R3", "pads in repair", pads - p0, PW);
    fix_one(0, 0, 2);
    fix_one(12, 3, 3);
    fix_one(4, 1, 3);
    image_matches(1, "R7");
  endtask

  task automatic t_abort;
    bit ok;
    int r0, w0;
    @(negedge clk);
    host_abort = 1'b1;
    @(negedge clk);
    host_abort = 1'b0;
    wait_state(2'd0, 3, ok);
    chk(ok || st_state == 2'd0, "R10", "idle after abort", int'(st_state), 0);
    r0 = rd_strobes; w0 = wr_strobes;
    idle_cycles(20);
    chk(rd_strobes == r0 && wr_strobes == w0, "R10", "strobes after abort",
        (rd_strobes - r0) + (wr_strobes - w0), 0);
    @(negedge clk); model_clr = 1'b1;
    @(negedge clk); model_clr = 1'b0;
  endtask

  initial begin
    idle_cycles(3);
    rst_n = 1'b1;
    t_reset();
    t_load_only();
    t_load_scrub();
    t_masked();
    t_busy_start();
    t_fix_and_saturate();
    t_abort();
    if (!wd_hit) begin
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #80000;
    wd_hit = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end
endmodule